// File: doc/BRIEF.md
# Chip-Select Gated Registered Fanout Buffer

This block sits between a memory controller and a bank of DRAM devices. On every rising clock edge it captures a 14-bit command/address word and drives it out as two identical copies, A and B, so that each copy can feed half of the device load. The same registers also carry three per-rank control signals: clock enable, on-die termination and chip select. Each is registered and driven out on both copies.

The registered data word updates only while at least one of the two chip-select inputs is low. When both are high, the data copies keep their previous value. The clock-enable, termination and chip-select registers ignore this gating and follow their inputs on every edge.

An active-low reset clears every register. It drives all outputs low as soon as it is asserted, with no clock edge needed, and it overrides the chip-select gating. Reset release goes through a two-stage synchronizer. The outputs therefore stay low through the first two rising edges after release and capture fresh data on the third.

Top module: `csgate_fanout_reg`

## Requirements
- R1: On a rising edge where `cs_n` or `cs_aux_n` is low and the block is out of reset, `q_a` and `q_b` take the value of `d` sampled at that edge, visible after that edge.
- R2: Every A output always equals its B counterpart: `q_a`/`q_b`, `qcs_a`/`qcs_b`, `qcke_a`/`qcke_b` and `qodt_a`/`qodt_b`.
- R3: On a rising edge where `cs_n` and `cs_aux_n` are both high, `q_a` and `q_b` keep their previous value whatever `d` is.
- R4: `qcke_*` and `qodt_*` take `cke` and `odt` on every rising edge out of reset, whatever the chip-select inputs are.
- R5: `qcs_*` takes `cs_n` on every rising edge out of reset, including edges where the data word is held.
- R6: While `rst_n` is low, every output is 0. When `rst_n` falls, the outputs clear at once, without waiting for a clock edge.
- R7: Reset overrides chip-select gating. A held data word is cleared to 0 when `rst_n` falls.
- R8: After `rst_n` rises, all outputs stay 0 through the first and second rising edges. The third rising edge captures the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; capture on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized |
| d | input | 14 | Command/address word |
| cs_n | input | 1 | Primary chip select, active low; registered to `qcs_*` |
| cs_aux_n | input | 1 | Secondary chip select, active low; used only for gating |
| cke | input | 1 | Clock enable to be redriven |
| odt | input | 1 | On-die termination to be redriven |
| q_a | output | 14 | Registered data word, copy A |
| q_b | output | 14 | Registered data word, copy B |
| qcs_a | output | 1 | Registered chip select, copy A |
| qcs_b | output | 1 | Registered chip select, copy B |
| qcke_a | output | 1 | Registered clock enable, copy A |
| qcke_b | output | 1 | Registered clock enable, copy B |
| qodt_a | output | 1 | Registered termination, copy A |
| qodt_b | output | 1 | Registered termination, copy B |

## Verification
In normal operation every result is due one rising edge after its stimulus. The bench drives inputs on the falling edge, lets exactly one rising edge pass and samples on the next falling edge, so each check sees the result of one capture only. Reset assertion is checked half a clock phase after `rst_n` falls, before any rising edge can occur. Reset release is checked after the first, second and third rising edges: zero is expected after the first two and the driven word after the third.

// File: rtl/csgate_pkg.sv
package csgate_pkg;

    parameter int WORD_W      = 14;
    parameter int SYNC_STAGES = 2;
    localparam int COPIES     = 2;

    typedef logic [WORD_W-1:0] word_t;

    // Per-rank control bundle, never gated by chip select
    typedef struct packed {
        logic sel_n;
        logic ck_en;
        logic term;
    } rank_ctl_t;

    localparam rank_ctl_t CTL_CLEAR = '{sel_n: 1'b0, ck_en: 1'b0, term: 1'b0};

    // Data word holds only when both chip selects are inactive (high)
    function automatic logic both_deselected(input logic sel_a_n, input logic sel_b_n);
        return sel_a_n & sel_b_n;
    endfunction

endpackage

// File: rtl/csgate_rst_sync.sv
module csgate_rst_sync #(
    parameter int STAGES = csgate_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_ok
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_ok = chain[STAGES-1];

    // R6: the synchronized reset is low whenever the raw reset is low
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            a_r6_sync_follows: assert (rst_ok == 1'b0);
        end
    end
endmodule

// File: rtl/csgate_data_bank.sv
module csgate_data_bank
    import csgate_pkg::*;
#(
    parameter int WIDTH = WORD_W
) (
    input  logic             clk,
    input  logic             rst_ok,
    input  logic             hold,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_ok) begin
        if (!rst_ok)    q <= '0;
        else if (!hold) q <= d;
    end

    // Assertion scaffolding: marks that the previous edge was a live one
    logic live_q;
    always_ff @(posedge clk or negedge rst_ok) begin
        if (!rst_ok) live_q <= 1'b0;
        else         live_q <= 1'b1;
    end

    a_r3_hold_word: assert property (@(posedge clk) disable iff (!rst_ok)
        (live_q && $past(hold)) |-> $stable(q));

    a_r1_capture_word: assert property (@(posedge clk) disable iff (!rst_ok)
        (live_q && !$past(hold)) |-> (q == $past(d)));
endmodule

// File: rtl/csgate_ctl_bank.sv
module csgate_ctl_bank
    import csgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_ok,
    input  rank_ctl_t ctl_in,
    output rank_ctl_t ctl_q
);
    always_ff @(posedge clk or negedge rst_ok) begin
        if (!rst_ok) ctl_q <= CTL_CLEAR;
        else         ctl_q <= ctl_in;
    end

    logic live_q;
    always_ff @(posedge clk or negedge rst_ok) begin
        if (!rst_ok) live_q <= 1'b0;
        else         live_q <= 1'b1;
    end

    // R4 and R5: control bits follow their inputs regardless of gating
    a_r4_ctl_follow: assert property (@(posedge clk) disable iff (!rst_ok)
        live_q |-> (ctl_q.ck_en == $past(ctl_in.ck_en) && ctl_q.term == $past(ctl_in.term)));

    a_r5_sel_follow: assert property (@(posedge clk) disable iff (!rst_ok)
        live_q |-> (ctl_q.sel_n == $past(ctl_in.sel_n)));
endmodule

// File: rtl/csgate_fanout_reg.sv
module csgate_fanout_reg
    import csgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] d,
    input  logic              cs_n,
    input  logic              cs_aux_n,
    input  logic              cke,
    input  logic              odt,
    output logic [WORD_W-1:0] q_a,
    output logic [WORD_W-1:0] q_b,
    output logic              qcs_a,
    output logic              qcs_b,
    output logic              qcke_a,
    output logic              qcke_b,
    output logic              qodt_a,
    output logic              qodt_b
);
    logic      rst_ok;
    logic      hold;
    rank_ctl_t ctl_in;
    word_t     word_q [COPIES];
    rank_ctl_t ctl_q  [COPIES];

    csgate_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .rst_ok (rst_ok)
    );

    assign hold   = both_deselected(cs_n, cs_aux_n);
    assign ctl_in = '{sel_n: cs_n, ck_en: cke, term: odt};

    // One register bank per output copy, so each copy drives its own load
    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        csgate_data_bank #(.WIDTH(WORD_W)) u_data (
            .clk    (clk),
            .rst_ok (rst_ok),
            .hold   (hold),
            .d      (d),
            .q      (word_q[g])
        );
        csgate_ctl_bank u_ctl (
            .clk    (clk),
            .rst_ok (rst_ok),
            .ctl_in (ctl_in),
            .ctl_q  (ctl_q[g])
        );
    end

    assign q_a    = word_q[0];
    assign q_b    = word_q[1];
    assign qcs_a  = ctl_q[0].sel_n;
    assign qcs_b  = ctl_q[1].sel_n;
    assign qcke_a = ctl_q[0].ck_en;
    assign qcke_b = ctl_q[1].ck_en;
    assign qodt_a = ctl_q[0].term;
    assign qodt_b = ctl_q[1].term;

    // R2: the two copies never diverge
    always @(negedge clk) begin
        if (rst_n === 1'b1 || rst_n === 1'b0) begin
            a_r2_copies_match: assert ({q_a, qcs_a, qcke_a, qodt_a} == {q_b, qcs_b, qcke_b, qodt_b});
        end
    end

    // R6/R7: reset low forces every output low, held word included
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            a_r6_reset_low: assert ({q_a, q_b, qcs_a, qcs_b, qcke_a, qcke_b, qodt_a, qodt_b} == '0);
        end
    end
endmodule

// File: tb/tb_csgate_fanout_reg.sv
`timescale 1ns/100ps
module tb_csgate_fanout_reg;
    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] d;
    logic         cs_n, cs_aux_n, cke, odt;
    logic [W-1:0] q_a, q_b;
    logic         qcs_a, qcs_b, qcke_a, qcke_b, qodt_a, qodt_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    csgate_fanout_reg dut (
        .clk(clk), .rst_n(rst_n), .d(d), .cs_n(cs_n), .cs_aux_n(cs_aux_n),
        .cke(cke), .odt(odt), .q_a(q_a), .q_b(q_b),
        .qcs_a(qcs_a), .qcs_b(qcs_b), .qcke_a(qcke_a), .qcke_b(qcke_b),
        .qodt_a(qodt_a), .qodt_b(qodt_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Checks every output on both copies against expected values
    task automatic check_all(input string req, input logic [W-1:0] ew,
                             input logic ecs, input logic ecke, input logic eodt);
        check({req, " q_a"},    32'(q_a), 32'(ew));
        check({req, " q_b"},    32'(q_b), 32'(ew));
        check({req, " ctl_a"},  32'({qcs_a, qcke_a, qodt_a}), 32'({ecs, ecke, eodt}));
        check({req, " ctl_b"},  32'({qcs_b, qcke_b, qodt_b}), 32'({ecs, ecke, eodt}));
    endtask

    task automatic drive(input logic [W-1:0] w, input logic c0, input logic c1,
                         input logic ce, input logic ot);
        d = w; cs_n = c0; cs_aux_n = c1; cke = ce; odt = ot;
    endtask

    // one rising edge, then sample point at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_and_release();
        @(negedge clk);
        drive(14'h3FFF, 1'b0, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step();
            check_all("R6 held in reset", '0, 1'b0, 1'b0, 1'b0);
        end
        rst_n = 1'b1;
        step();
        check_all("R8 first edge after release", '0, 1'b0, 1'b0, 1'b0);
        step();
        check_all("R8 second edge after release", '0, 1'b0, 1'b0, 1'b0);
        step();
        check_all("R8 third edge captures", 14'h3FFF, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_update();
        logic [W-1:0] pats [4] = '{14'h1555, 14'h2AAA, 14'h0001, 14'h2000};
        for (int i = 0; i < 4; i++) begin
            drive(pats[i], 1'b0, 1'b1, i[0], ~i[0]);
            step();
            check_all("R1 R2 update cs_n low", pats[i], 1'b0, i[0], ~i[0]);
        end
        for (int i = 0; i < 4; i++) begin
            drive(~pats[i], 1'b1, 1'b0, ~i[0], i[0]);
            step();
            check_all("R1 R2 update cs_aux_n low", ~pats[i], 1'b1, ~i[0], i[0]);
        end
    endtask

    task automatic t_hold();
        drive(14'h1234, 1'b0, 1'b0, 1'b0, 1'b0);
        step();
        check_all("R1 preload", 14'h1234, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            drive(14'h0F0F ^ W'(i), 1'b1, 1'b1, i[0], i[1]);
            step();
            check_all("R3 R4 R5 hold with control follow", 14'h1234, 1'b1, i[0], i[1]);
        end
        drive(14'h0ABC, 1'b1, 1'b0, 1'b1, 1'b0);
        step();
        check_all("R1 resume after hold", 14'h0ABC, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_async_reset();
        drive(14'h2468, 1'b0, 1'b1, 1'b1, 1'b1);
        step();
        drive(14'h1111, 1'b1, 1'b1, 1'b1, 1'b1);
        step();
        check_all("R3 held before reset", 14'h2468, 1'b1, 1'b1, 1'b1);
        @(posedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        check_all("R6 R7 clear without edge", '0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(14'h0777, 1'b0, 1'b0, 1'b0, 1'b1);
        step();
        check_all("R8 second release edge1", '0, 1'b0, 1'b0, 1'b0);
        step();
        check_all("R8 second release edge2", '0, 1'b0, 1'b0, 1'b0);
        step();
        check_all("R8 second release edge3", 14'h0777, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0;
        drive('0, 1'b1, 1'b1, 1'b0, 1'b0);
        t_reset_and_release();
        t_update();
        t_hold();
        t_async_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule